// File: doc/BRIEF.md
# Jack Patch Detection Probe

This block tells whether a jack input has a cable in it. While the jack is empty, its normalization network feeds the probe line back into the ADC. The block drives a pseudo-random bit onto that line and advances it once for every ADC sample strobe. It slices each returned ADC code into a bit by comparing it with a programmable mid threshold. It then compares that bit with the probe value that was driven a selectable number of strobes earlier.

Mismatches are counted over a fixed window of consecutive samples. When a window closes, a registered flag is updated. A window with only a few mismatches shows that the probe came back, so the jack is empty. Any other result means that a cable, or some other source, is driving the input. The same block serves control-voltage inputs and trigger inputs.

Top module: `jack_probe_detect`

## Requirements
- R1: While reset is held, and until the first strobe, `probe_bit` equals bit 15 of the seed (seed 0xACE1, so 1) and `patched` is 1.
- R2: The probe comes from a 16-bit LFSR that moves one step per strobe. The state shifts toward the MSB. The new bit 0 is the XOR of bits 15, 13, 12 and 10. `probe_bit` is bit 15. The state is never zero.
- R3: The readback bit is 1 only when `sample_code` is strictly greater than `mid_thresh`. A code equal to the threshold reads as 0.
- R4: On a strobe with `align_dly` = d (0 to 3), the readback bit is compared with the probe value driven d strobes earlier. d = 0 means the value driven during this sample. Probe history from before reset counts as 0.
- R5: Windows are 32 strobes long and are counted from reset. One clock after the 32nd strobe of a window, `patched` becomes 0 if that window had 2 or fewer mismatches, and 1 otherwise.
- R6: `patched` keeps its value on every clock that does not end a window.
- R7: `probe_bit` changes only on the clock that follows a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_stb | input | 1 | One-cycle pulse per ADC sample |
| sample_code | input | 12 | ADC code of the returned sample |
| mid_thresh | input | 12 | Slicing threshold |
| align_dly | input | 2 | Drive-to-readback delay, in strobes |
| probe_bit | output | 1 | Bit driven onto the normalization line |
| patched | output | 1 | 1 when the input is taken as patched |

## Verification
The probe bit and the mismatch count respond on the first clock after a strobe. The patched flag responds only on the first clock after the 32nd strobe of a window, so a stimulus affects the flag between one clock and one full window later. The bench drives inputs on falling edges and keeps a behavioural model that it advances with exactly the inputs it has just applied. On the next falling edge it compares both outputs with that model, which places every sample one register stage after the stimulus. The scenario checks on the flag are made right after the clock that follows a window's last strobe. Every run is a whole number of windows long, so these checks always fall on a window boundary.

// File: rtl/jpd_pkg.sv
package jpd_pkg;

   // Feedback tap masks for maximal-length Fibonacci LFSRs (bit i = stage i+1)
   function automatic logic [31:0] lfsr_taps(input int width);
      case (width)
         8:       return 32'h0000_00B8;
         16:      return 32'h0000_B400;
         24:      return 32'h00E1_0000;
         32:      return 32'h8020_0003;
         default: return 32'h0000_0000;
      endcase
   endfunction

endpackage

// File: rtl/probe_lfsr.sv
module probe_lfsr #(
   parameter int          W    = 16,
   parameter logic [31:0] SEED = 32'h0000_ACE1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         adv,
   output logic [W-1:0] state,
   output logic         bit_out
);
   import jpd_pkg::*;

   localparam logic [31:0] TAPS_FULL = lfsr_taps(W);
   localparam logic [W-1:0] TAPS     = TAPS_FULL[W-1:0];
   localparam logic [W-1:0] SEED_W   = SEED[W-1:0];

   generate
      if (TAPS_FULL == 32'd0) begin : g_bad_width
         $error("probe_lfsr: unsupported width");
      end
      if (SEED_W == '0) begin : g_bad_seed
         $error("probe_lfsr: seed must be non-zero");
      end
   endgenerate

   logic fb;
   assign fb = ^(state & TAPS);

   always_ff @(posedge clk) begin
      if (!rst_n)   state <= SEED_W;
      else if (adv) state <= {state[W-2:0], fb};
   end

   assign bit_out = state[W-1];
endmodule

// File: rtl/probe_align.sv
module probe_align #(
   parameter int DEPTH = 3,
   parameter int SW    = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          adv,
   input  logic          cur_bit,
   input  logic [SW-1:0] sel,
   output logic          ref_bit
);
   generate
      if (DEPTH < 1) begin : g_bad_depth
         $error("probe_align: DEPTH must be at least 1");
      end
   endgenerate

   logic [DEPTH-1:0] hist;
   logic [DEPTH:0]   taps;

   genvar gi;
   generate
      for (gi = 0; gi < DEPTH; gi++) begin : g_stage
         if (gi == 0) begin : g_head
            always_ff @(posedge clk) begin
               if (!rst_n)   hist[gi] <= 1'b0;
               else if (adv) hist[gi] <= cur_bit;
            end
         end else begin : g_body
            always_ff @(posedge clk) begin
               if (!rst_n)   hist[gi] <= 1'b0;
               else if (adv) hist[gi] <= hist[gi-1];
            end
         end
      end
   endgenerate

   assign taps = {hist, cur_bit};

   always_comb begin
      if (int'(sel) > DEPTH) ref_bit = taps[DEPTH];
      else                   ref_bit = taps[sel];
   end
endmodule

// File: rtl/miss_window.sv
module miss_window #(
   parameter int WINDOW   = 32,
   parameter int MAX_MISS = 2,
   parameter int CW       = 5,
   parameter int MW       = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          adv,
   input  logic          miss,
   output logic [MW-1:0] miss_cnt,
   output logic          flag
);
   localparam logic [CW-1:0] LAST  = CW'(WINDOW - 1);
   localparam logic [MW-1:0] LIMIT = MW'(MAX_MISS);

   logic [CW-1:0] pos;
   logic [MW-1:0] miss_next;

   assign miss_next = miss_cnt + MW'(miss);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pos      <= '0;
         miss_cnt <= '0;
         flag     <= 1'b1;
      end else if (adv) begin
         if (pos == LAST) begin
            pos      <= '0;
            miss_cnt <= '0;
            flag     <= (miss_next > LIMIT);
         end else begin
            pos      <= pos + CW'(1);
            miss_cnt <= miss_next;
         end
      end
   end
endmodule

// File: rtl/jack_probe_detect.sv
module jack_probe_detect #(
   parameter int          SAMPLE_W = 12,
   parameter int          LFSR_W   = 16,
   parameter logic [31:0] SEED     = 32'h0000_ACE1,
   parameter int          WINDOW   = 32,
   parameter int          MAX_MISS = 2,
   parameter int          DLY_MAX  = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                sample_stb,
   input  logic [SAMPLE_W-1:0] sample_code,
   input  logic [SAMPLE_W-1:0] mid_thresh,
   input  logic [1:0]          align_dly,
   output logic                probe_bit,
   output logic                patched
);
   localparam int CW = (WINDOW > 1) ? $clog2(WINDOW) : 1;
   localparam int MW = $clog2(WINDOW + 1);

   generate
      if (SAMPLE_W < 1) begin : g_bad_sw
         $error("jack_probe_detect: SAMPLE_W must be positive");
      end
      if (WINDOW < 2) begin : g_bad_win
         $error("jack_probe_detect: WINDOW too small");
      end
      if (MAX_MISS >= WINDOW) begin : g_bad_miss
         $error("jack_probe_detect: MAX_MISS must be below WINDOW");
      end
      if (DLY_MAX > 3 || DLY_MAX < 1) begin : g_bad_dly
         $error("jack_probe_detect: DLY_MAX must be 1 to 3");
      end
   endgenerate

   logic [LFSR_W-1:0] lfsr_state;
   logic              ref_bit;
   logic              rd_bit;
   logic              miss;
   logic [MW-1:0]     miss_cnt;

   probe_lfsr #(.W(LFSR_W), .SEED(SEED)) u_lfsr (
      .clk     (clk),
      .rst_n   (rst_n),
      .adv     (sample_stb),
      .state   (lfsr_state),
      .bit_out (probe_bit)
   );

   probe_align #(.DEPTH(DLY_MAX), .SW(2)) u_align (
      .clk     (clk),
      .rst_n   (rst_n),
      .adv     (sample_stb),
      .cur_bit (probe_bit),
      .sel     (align_dly),
      .ref_bit (ref_bit)
   );

   assign rd_bit = (sample_code > mid_thresh);
   assign miss   = rd_bit ^ ref_bit;

   miss_window #(.WINDOW(WINDOW), .MAX_MISS(MAX_MISS), .CW(CW), .MW(MW)) u_win (
      .clk      (clk),
      .rst_n    (rst_n),
      .adv      (sample_stb),
      .miss     (miss),
      .miss_cnt (miss_cnt),
      .flag     (patched)
   );
endmodule

// File: rtl/jpd_chk.sv
module jpd_chk #(
   parameter int LFSR_W = 16,
   parameter int WINDOW = 32,
   parameter int MW     = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sample_stb,
   input logic              probe_bit,
   input logic              patched,
   input logic [LFSR_W-1:0] lfsr_state,
   input logic [MW-1:0]     miss_cnt
);
   localparam int CW = (WINDOW > 1) ? $clog2(WINDOW) : 1;
   localparam logic [CW-1:0] LAST = CW'(WINDOW - 1);

   logic [CW-1:0] c_pos;
   logic          c_first_done;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         c_pos        <= '0;
         c_first_done <= 1'b0;
      end else if (sample_stb) begin
         c_pos <= (c_pos == LAST) ? '0 : c_pos + CW'(1);
         if (c_pos == LAST) c_first_done <= 1'b1;
      end
   end

   // R2
   lfsr_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sample_stb |=> lfsr_state[LFSR_W-1:1] == $past(lfsr_state[LFSR_W-2:0]));

   // R2
   lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lfsr_state != '0);

   // R7
   probe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sample_stb |=> $stable(probe_bit));

   // R6
   flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(sample_stb && c_pos == LAST) |=> $stable(patched));

   // R5
   first_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !c_first_done |-> patched);

   // R5
   miss_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int'(miss_cnt) <= int'(c_pos));
endmodule

bind jack_probe_detect jpd_chk #(.LFSR_W(LFSR_W), .WINDOW(WINDOW), .MW(MW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .sample_stb (sample_stb),
   .probe_bit  (probe_bit),
   .patched    (patched),
   .lfsr_state (lfsr_state),
   .miss_cnt   (miss_cnt)
);

// File: tb/sim_jack_probe_detect.sv
module sim_jack_probe_detect;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sample_stb = 1'b0;
   logic [11:0] sample_code = '0;
   logic [11:0] mid_thresh = 12'd2048;
   logic [1:0]  align_dly = '0;
   logic        probe_bit;
   logic        patched;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   // behavioural reference state
   int m_lfsr;
   int m_cnt;
   int m_miss;
   bit m_patched;
   bit past [0:7];

   always #5 clk = ~clk;

   jack_probe_detect u0 (
      .clk(clk), .rst_n(rst_n), .sample_stb(sample_stb),
      .sample_code(sample_code), .mid_thresh(mid_thresh),
      .align_dly(align_dly), .probe_bit(probe_bit), .patched(patched)
   );

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         errors++;
         $display("FAIL watchdog expired: actual %0d cycles expected < 150000", cycles);
         finish_run();
      end
   end

   task automatic chk(input bit act, input bit exp, input string what);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0b expected %0b", what, act, exp);
      end
   endtask

   function automatic bit m_probe();
      return bit'((m_lfsr >> 15) & 1);
   endfunction

   // one falling edge: compare, then drive and advance the model
   task automatic step(input bit stb_v, input logic [11:0] code_v, input logic [1:0] d);
      bit rd, mis, fb;
      @(negedge clk);
      chk(probe_bit, m_probe(), "R2 R7 probe_bit vs model");
      chk(patched, m_patched, "R5 R6 patched vs model");
      sample_stb  = stb_v;
      sample_code = code_v;
      align_dly   = d;
      if (stb_v) begin
         rd  = (int'(code_v) > int'(mid_thresh));
         mis = (rd != past[d]);
         if (m_cnt == 31) begin
            m_patched = ((m_miss + int'(mis)) > 2);
            m_miss = 0;
            m_cnt = 0;
         end else begin
            m_miss += int'(mis);
            m_cnt++;
         end
         fb = bit'(((m_lfsr >> 15) ^ (m_lfsr >> 13) ^ (m_lfsr >> 12) ^ (m_lfsr >> 10)) & 1);
         m_lfsr = ((m_lfsr << 1) | int'(fb)) & 32'hFFFF;
         for (int k = 7; k > 0; k--) past[k] = past[k-1];
         past[0] = m_probe();
      end
   endtask

   // mode 0: loopback with physical delay p, 1: random, 2: constant hi
   task automatic run(input int mode, input int nwin, input int flips, input int p,
                      input logic [1:0] d, input logic [11:0] hi, input logic [11:0] lo);
      bit b;
      for (int s = 0; s < nwin * 32; s++) begin
         if (mode == 0) begin
            b = past[p];
            if (m_cnt < flips) b = ~b;
         end else if (mode == 1) b = bit'($urandom & 1);
         else b = 1'b1;
         step(1'b1, b ? hi : lo, d);
         step(1'b0, b ? hi : lo, d);
      end
   endtask

   initial begin
      m_lfsr = 32'hACE1;
      m_cnt = 0;
      m_miss = 0;
      m_patched = 1'b1;
      for (int k = 0; k < 8; k++) past[k] = 1'b0;
      past[0] = 1'b1;
      repeat (3) @(negedge clk);
      // R1 reset values while reset is held
      chk(probe_bit, 1'b1, "R1 probe_bit in reset");
      chk(patched, 1'b1, "R1 patched in reset");
      rst_n = 1'b1;
      step(1'b0, 12'd0, 2'd0);
      step(1'b0, 12'd0, 2'd0);

      // R5 clean loopback, no delay
      run(0, 2, 0, 0, 2'd0, 12'd3000, 12'd1000);
      chk(patched, 1'b0, "R5 loopback d0 unpatched");
      // R4 R5 two flips per window, delay 2
      run(0, 2, 2, 2, 2'd2, 12'd3000, 12'd1000);
      chk(patched, 1'b0, "R4 R5 two flips tolerated");
      // R5 three flips per window
      run(0, 2, 3, 2, 2'd2, 12'd3000, 12'd1000);
      chk(patched, 1'b1, "R5 three flips patched");
      // R4 delay 3 aligned
      run(0, 2, 0, 3, 2'd3, 12'd3000, 12'd1000);
      chk(patched, 1'b0, "R4 delay 3 aligned");
      // R6 half window of random input keeps flag
      run(1, 0, 0, 0, 2'd3, 12'd3000, 12'd1000);
      for (int s = 0; s < 16; s++) begin
         step(1'b1, ($urandom & 1) ? 12'd3000 : 12'd1000, 2'd3);
         step(1'b0, 12'd1000, 2'd3);
      end
      chk(patched, 1'b0, "R6 flag held mid window");
      for (int s = 0; s < 16; s++) begin
         step(1'b1, past[3] ? 12'd3000 : 12'd1000, 2'd3);
         step(1'b0, 12'd1000, 2'd3);
      end
      // R4 misaligned delay
      run(0, 2, 0, 3, 2'd0, 12'd3000, 12'd1000);
      chk(patched, 1'b1, "R4 misaligned delay patched");
      // R5 independent random source
      run(1, 2, 0, 0, 2'd1, 12'd3000, 12'd1000);
      chk(patched, 1'b1, "R5 random source patched");
      // R5 constant input
      run(2, 2, 0, 0, 2'd1, 12'd3000, 12'd1000);
      chk(patched, 1'b1, "R5 constant input patched");
      // R3 equal-to-threshold reads as 0
      run(0, 2, 0, 1, 2'd1, 12'd2049, 12'd2048);
      chk(patched, 1'b0, "R3 threshold plus one vs equal");
      run(0, 2, 0, 1, 2'd1, 12'd2048, 12'd2048);
      chk(patched, 1'b1, "R3 equal code reads 0");
      // R7 idle cycles with no strobe
      for (int s = 0; s < 20; s++) step(1'b0, 12'd3000, 2'd0);
      chk(patched, 1'b1, "R6 idle keeps flag");
      finish_run();
   end
endmodule